// File: doc/BRIEF.md
# SDRAM Area Decoder and Command Sequencer

This block turns a CPU-side bus request into the command stream for an external synchronous DRAM. It compares the physical address against two 64 MB memory areas (area 2 and area 3). A 3-bit memory-type code decides which of these areas hold SDRAM. For an SDRAM hit, the block opens the row, waits a fixed row-to-column delay, and then issues one or more column commands. The last column command always carries auto-precharge.

Each area has its own chip select. The row and column strobes come in two pairs, one for the upper 32 MB half of an area and one for the lower half. An access drives only the pair that matches its address. Refresh, self-refresh entry and mode-register writes drive both pairs at once. Cache line transfers always move 16 bytes as single-beat column commands: four of them on a 32-bit bus and eight on a 16-bit bus. Any other access is a single column command with per-byte-lane masks.

Top module: `sdram_area_seq`

## Requirements
- R1: Area 2 is addresses 0x08000000–0x0BFFFFFF and area 3 is addresses 0x0C000000–0x0FFFFFFF. With `mem_type_i` = 3'b011 both areas are SDRAM. With 3'b010 only area 3 is SDRAM. Any other code makes neither area SDRAM. A request to a non-SDRAM address is ignored: `ready_o` stays 1 and every select, strobe and mask stays inactive. Refresh, mode-set and self-refresh requests are ignored when neither area is SDRAM.
- R2: Address bit 25 picks the strobe pair: 1 uses `row_hi_n_o`/`col_hi_n_o` and 0 uses `row_lo_n_o`/`col_lo_n_o`. During an access, the other pair stays high.
- R3: Commands are encoded active-low on {row, col, wr}: ACTV=011, READ=101, WRIT=100, REF=001, MRS=000, NOP=111. When a request is accepted, ACTV appears in the following cycle with `addr_o` equal to the start address. This is followed by TRCD-1 NOP cycles (strobes high, selects high), and then the first column command.
- R4: A single access (`req_line_i`=0) issues exactly one column command, with `auto_pre_o`=1 and `addr_o` equal to the request address.
- R5: A line transfer issues 4 column commands on a 32-bit bus and 8 on a 16-bit bus (`bus16_i`=1), in consecutive cycles. `addr_o` starts at the 16-byte-aligned base and steps by 4 or by 2. Only the last command has `auto_pre_o`=1.
- R6: `byte_mask_o` bit i is an active-high mask for byte lane i, where lane i holds byte offset i. In column cycles the mask is set as follows. On a 32-bit bus: a byte (size 0) enables lane addr[1:0], a 16-bit word (size 1) enables lanes 2 and 3 when addr[1]=1 and lanes 0 and 1 otherwise, and a long (size 2) enables all lanes. On a 16-bit bus: a byte enables lane addr[0], any wider size enables lanes 0 and 1, and lanes 2 and 3 stay masked. A line transfer enables all four lanes. In all other cycles the mask is 4'hF.
- R7: A refresh request produces one REF cycle. Both strobe pairs are low and `wr_n_o` is high. The select of every area that is SDRAM is asserted.
- R8: A mode-set request produces one MRS cycle. Both pairs and `wr_n_o` are low, and `addr_o` equals `req_addr_i` sampled with the request.
- R9: Self-refresh entry issues REF with `clk_en_o`=0. `clk_en_o` then stays 0, with NOP and no selects, until `self_exit_i`. Requests are ignored during this time. `clk_en_o` is 1 in every other cycle.
- R10: Row, column and write strobes are low only in cycles where at least one area select is low.
- R11: Requests are sampled only while `ready_o`=1, which holds only in the idle state. When several requests arrive in the same cycle, the priority is self-refresh entry, then refresh, then mode set, then access.
- R12: After reset, `ready_o`=1, `clk_en_o`=1, and all selects and strobes are high with the mask at 4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| req_addr_i | input | ADDR_W | Physical address, also mode value for mode set |
| req_we_i | input | 1 | 1 = write |
| req_size_i | input | 2 | 0 byte, 1 word, 2 long |
| req_line_i | input | 1 | 16-byte line transfer |
| mem_type_i | input | 3 | Memory-type code |
| bus16_i | input | 1 | 1 = 16-bit data bus |
| refresh_i | input | 1 | Auto-refresh request |
| self_enter_i | input | 1 | Enter self-refresh |
| self_exit_i | input | 1 | Leave self-refresh |
| mode_set_i | input | 1 | Mode-register write request |
| ready_o | output | 1 | Idle, accepting requests |
| area2_sel_n_o | output | 1 | Area 2 chip select |
| area3_sel_n_o | output | 1 | Area 3 chip select |
| row_hi_n_o | output | 1 | Row strobe, upper half |
| row_lo_n_o | output | 1 | Row strobe, lower half |
| col_hi_n_o | output | 1 | Column strobe, upper half |
| col_lo_n_o | output | 1 | Column strobe, lower half |
| wr_n_o | output | 1 | Shared write strobe |
| auto_pre_o | output | 1 | Auto-precharge flag of a column command |
| byte_mask_o | output | 4 | Byte-lane masks, 1 = masked |
| clk_en_o | output | 1 | SDRAM clock enable |
| addr_o | output | ADDR_W | Row/column/mode address |

## Verification
The address patterns are chosen to separate three things. Values on either side of 0x0A000000, 0x0C000000 and 0x10000000 separate an error in the half-select bit from an error in the area decode. The same area 2 address is also tried under codes 010 and 011, which isolates the memory-type decision. Line transfers are run with both bus widths and at unaligned start addresses. This distinguishes a wrong beat count from a wrong base alignment or a wrong step. Byte and word accesses at every low-address offset expose lane-order errors in the masks. Simultaneous refresh, mode-set, self-refresh and access requests check the priority order. Constrained-random traffic then mixes all of these cases.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // {row_n, col_n, wr_n}
  typedef enum logic [2:0] {
    CMD_MRS  = 3'b000,
    CMD_REF  = 3'b001,
    CMD_PALL = 3'b010,
    CMD_ACTV = 3'b011,
    CMD_WRIT = 3'b100,
    CMD_READ = 3'b101,
    CMD_NOP  = 3'b111
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_WAIT, ST_COL, ST_REF, ST_MRS, ST_SELF_IN, ST_SELF
  } seq_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
endpackage

// File: rtl/sdram_area_dec.sv
module sdram_area_dec #(
  parameter int ADDR_W   = 32,
  parameter int HALF_BIT = 25
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        mem_type_i,
  output logic              hit_o,
  output logic              area3_o,
  output logic              upper_o,
  output logic              sd2_o,
  output logic              sd3_o
);
  localparam int AREA_LSB = HALF_BIT + 1;
  localparam int HI_W     = ADDR_W - AREA_LSB;

  logic [HI_W-1:0] hi;
  logic            is2, is3;

  assign hi      = addr_i[ADDR_W-1:AREA_LSB];
  assign is2     = (hi == HI_W'(2));
  assign is3     = (hi == HI_W'(3));
  assign sd2_o   = (mem_type_i == 3'b011);
  assign sd3_o   = (mem_type_i == 3'b011) || (mem_type_i == 3'b010);
  assign hit_o   = (is2 && sd2_o) || (is3 && sd3_o);
  assign area3_o = is3;
  assign upper_o = addr_i[HALF_BIT];
endmodule

// File: rtl/sdram_lane_mask.sv
module sdram_lane_mask
  import sdram_seq_pkg::*;
(
  input  logic [1:0] size_i,
  input  logic [1:0] lo_i,
  input  logic       line_i,
  input  logic       bus16_i,
  output logic [3:0] mask_o
);
  logic [3:0] en;

  always_comb begin
    en = 4'b0000;
    if (line_i) begin
      en = 4'hF;
    end else if (bus16_i) begin
      if (size_i == SZ_BYTE) en[{1'b0, lo_i[0]}] = 1'b1;
      else                   en = 4'b0011;
    end else begin
      case (size_i)
        SZ_BYTE: en[lo_i] = 1'b1;
        SZ_WORD: en = lo_i[1] ? 4'b1100 : 4'b0011;
        default: en = 4'hF;
      endcase
    end
  end

  assign mask_o = ~en;
endmodule

// File: rtl/sdram_cmd_fsm.sv
module sdram_cmd_fsm
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int TRCD       = 2,
  parameter int LINE_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              hit_i,
  input  logic              area3_i,
  input  logic              upper_i,
  input  logic              we_i,
  input  logic              line_i,
  input  logic              bus16_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        mask_i,
  input  logic              sd2_i,
  input  logic              sd3_i,
  input  logic              ref_i,
  input  logic              mrs_i,
  input  logic              self_in_i,
  input  logic              self_out_i,
  output sdram_cmd_e        cmd_o,
  output logic [1:0]        sel_n_o,   // {area3, area2}
  output logic              use_hi_o,
  output logic              use_lo_o,
  output logic [3:0]        mask_o,
  output logic              ap_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cke_o,
  output logic              ready_o
);
  localparam int BEATS32   = LINE_BYTES / 4;
  localparam int BEATS16   = LINE_BYTES / 2;
  localparam int CNT_W     = $clog2(BEATS16 + 1);
  localparam int WC_W      = $clog2(TRCD + 1);
  localparam int WAIT_LOAD = (TRCD > 2) ? TRCD - 2 : 0;

  seq_state_e        st;
  logic [WC_W-1:0]   wcnt;
  logic [CNT_W-1:0]  bcnt;
  logic [ADDR_W-1:0] cur_addr;
  logic              r_we, r_area3, r_upper, r_bus16;
  logic [3:0]        r_mask;
  logic [1:0]        r_sd;     // {area3, area2} SDRAM at command time
  logic              any_sd;

  assign any_sd = sd2_i || sd3_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_IDLE;
      wcnt     <= '0;
      bcnt     <= '0;
      cur_addr <= '0;
      r_we     <= 1'b0;
      r_area3  <= 1'b0;
      r_upper  <= 1'b0;
      r_bus16  <= 1'b0;
      r_mask   <= 4'hF;
      r_sd     <= 2'b00;
    end else begin
      case (st)
        ST_IDLE: begin
          r_sd <= {sd3_i, sd2_i};
          if (self_in_i && any_sd) begin
            st <= ST_SELF_IN;
          end else if (ref_i && any_sd) begin
            st <= ST_REF;
          end else if (mrs_i && any_sd) begin
            st       <= ST_MRS;
            cur_addr <= addr_i;
          end else if (req_i && hit_i) begin
            st       <= ST_ACT;
            r_we     <= we_i;
            r_area3  <= area3_i;
            r_upper  <= upper_i;
            r_bus16  <= bus16_i;
            r_mask   <= mask_i;
            cur_addr <= line_i ? (addr_i & ~ADDR_W'(LINE_BYTES - 1)) : addr_i;
            bcnt     <= !line_i ? '0 : (bus16_i ? CNT_W'(BEATS16 - 1) : CNT_W'(BEATS32 - 1));
          end
        end
        ST_ACT: begin
          wcnt <= WC_W'(WAIT_LOAD);
          st   <= (TRCD <= 1) ? ST_COL : ST_WAIT;
        end
        ST_WAIT: begin
          if (wcnt == '0) st <= ST_COL;
          else            wcnt <= wcnt - WC_W'(1);
        end
        ST_COL: begin
          if (bcnt == '0) begin
            st <= ST_IDLE;
          end else begin
            bcnt     <= bcnt - CNT_W'(1);
            cur_addr <= cur_addr + (r_bus16 ? ADDR_W'(2) : ADDR_W'(4));
          end
        end
        ST_REF, ST_MRS: st <= ST_IDLE;
        ST_SELF_IN:     st <= ST_SELF;
        ST_SELF:        if (self_out_i) st <= ST_IDLE;
        default:        st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_o    = CMD_NOP;
    sel_n_o  = 2'b11;
    use_hi_o = 1'b0;
    use_lo_o = 1'b0;
    mask_o   = 4'hF;
    ap_o     = 1'b0;
    cke_o    = 1'b1;
    case (st)
      ST_ACT: begin
        cmd_o    = CMD_ACTV;
        sel_n_o  = r_area3 ? 2'b01 : 2'b10;
        use_hi_o = r_upper;
        use_lo_o = !r_upper;
      end
      ST_COL: begin
        cmd_o    = r_we ? CMD_WRIT : CMD_READ;
        sel_n_o  = r_area3 ? 2'b01 : 2'b10;
        use_hi_o = r_upper;
        use_lo_o = !r_upper;
        mask_o   = r_mask;
        ap_o     = (bcnt == '0);
      end
      ST_REF, ST_MRS, ST_SELF_IN: begin
        cmd_o    = (st == ST_MRS) ? CMD_MRS : CMD_REF;
        sel_n_o  = ~r_sd;
        use_hi_o = 1'b1;
        use_lo_o = 1'b1;
        cke_o    = (st != ST_SELF_IN);
      end
      ST_SELF: cke_o = 1'b0;
      default: ;
    endcase
  end

  assign addr_o  = cur_addr;
  assign ready_o = (st == ST_IDLE);
endmodule

// File: rtl/sdram_area_seq.sv
module sdram_area_seq
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int HALF_BIT   = 25,
  parameter int TRCD       = 2,
  parameter int LINE_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_line_i,
  input  logic [2:0]        mem_type_i,
  input  logic              bus16_i,
  input  logic              refresh_i,
  input  logic              self_enter_i,
  input  logic              self_exit_i,
  input  logic              mode_set_i,
  output logic              ready_o,
  output logic              area2_sel_n_o,
  output logic              area3_sel_n_o,
  output logic              row_hi_n_o,
  output logic              row_lo_n_o,
  output logic              col_hi_n_o,
  output logic              col_lo_n_o,
  output logic              wr_n_o,
  output logic              auto_pre_o,
  output logic [3:0]        byte_mask_o,
  output logic              clk_en_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic       hit, area3, upper, sd2, sd3, use_hi, use_lo;
  logic [3:0] lane_mask;
  logic [1:0] sel_n;
  sdram_cmd_e cmd;
  logic [2:0] cmd_bits;

  sdram_area_dec #(.ADDR_W(ADDR_W), .HALF_BIT(HALF_BIT)) u_dec (
    .addr_i(req_addr_i), .mem_type_i(mem_type_i), .hit_o(hit),
    .area3_o(area3), .upper_o(upper), .sd2_o(sd2), .sd3_o(sd3)
  );

  sdram_lane_mask u_mask (
    .size_i(req_size_i), .lo_i(req_addr_i[1:0]), .line_i(req_line_i),
    .bus16_i(bus16_i), .mask_o(lane_mask)
  );

  sdram_cmd_fsm #(.ADDR_W(ADDR_W), .TRCD(TRCD), .LINE_BYTES(LINE_BYTES)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .hit_i(hit),
    .area3_i(area3), .upper_i(upper), .we_i(req_we_i), .line_i(req_line_i),
    .bus16_i(bus16_i), .addr_i(req_addr_i), .mask_i(lane_mask),
    .sd2_i(sd2), .sd3_i(sd3), .ref_i(refresh_i), .mrs_i(mode_set_i),
    .self_in_i(self_enter_i), .self_out_i(self_exit_i),
    .cmd_o(cmd), .sel_n_o(sel_n), .use_hi_o(use_hi), .use_lo_o(use_lo),
    .mask_o(byte_mask_o), .ap_o(auto_pre_o), .addr_o(addr_o),
    .cke_o(clk_en_o), .ready_o(ready_o)
  );

  assign cmd_bits      = cmd;
  assign area2_sel_n_o = sel_n[0];
  assign area3_sel_n_o = sel_n[1];
  // only the pair of the addressed half may pulse
  assign row_hi_n_o    = use_hi ? cmd_bits[2] : 1'b1;
  assign col_hi_n_o    = use_hi ? cmd_bits[1] : 1'b1;
  assign row_lo_n_o    = use_lo ? cmd_bits[2] : 1'b1;
  assign col_lo_n_o    = use_lo ? cmd_bits[1] : 1'b1;
  assign wr_n_o        = cmd_bits[0];
endmodule

// File: rtl/sdram_area_seq_chk.sv
module sdram_area_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              self_enter_i,
  input logic              ready_o,
  input logic              area2_sel_n_o,
  input logic              area3_sel_n_o,
  input logic              row_hi_n_o,
  input logic              row_lo_n_o,
  input logic              col_hi_n_o,
  input logic              col_lo_n_o,
  input logic              wr_n_o,
  input logic              auto_pre_o,
  input logic [3:0]        byte_mask_o,
  input logic              clk_en_o,
  input logic [ADDR_W-1:0] addr_o
);
  logic any_strobe, any_sel;
  assign any_strobe = !row_hi_n_o || !row_lo_n_o || !col_hi_n_o || !col_lo_n_o || !wr_n_o;
  assign any_sel    = !area2_sel_n_o || !area3_sel_n_o;

  assert_strobe_needs_sel_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_strobe |-> any_sel);

  assert_both_pairs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!row_hi_n_o && !row_lo_n_o) |-> (!col_hi_n_o && !col_lo_n_o));

  assert_cke_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_en_o) |-> $past(self_enter_i && ready_o));

  assert_ap_on_column_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_pre_o |-> (row_hi_n_o && row_lo_n_o && (col_hi_n_o != col_lo_n_o)));

  assert_mask_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_hi_n_o && col_lo_n_o) |-> (byte_mask_o == 4'hF));

  assert_ready_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!any_sel && clk_en_o));
endmodule

bind sdram_area_seq sdram_area_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sdram_area_seq_tb_top.sv
module sdram_area_seq_tb_top;
  localparam int TRCD = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 0, req_we_i = 0, req_line_i = 0, bus16_i = 0;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic [2:0]  mem_type_i = 3'b011;
  logic        refresh_i = 0, self_enter_i = 0, self_exit_i = 0, mode_set_i = 0;
  logic        ready_o, area2_sel_n_o, area3_sel_n_o, row_hi_n_o, row_lo_n_o;
  logic        col_hi_n_o, col_lo_n_o, wr_n_o, auto_pre_o, clk_en_o;
  logic [3:0]  byte_mask_o;
  logic [31:0] addr_o;

  int n_tests = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  sdram_area_seq #(.TRCD(TRCD)) dut_i (.*);

  localparam logic [12:0] IDLE_V = {7'b1111111, 1'b0, 4'hF, 1'b1};

  function automatic logic [12:0] obs();
    return {area2_sel_n_o, area3_sel_n_o, row_hi_n_o, row_lo_n_o, col_hi_n_o,
            col_lo_n_o, wr_n_o, auto_pre_o, byte_mask_o, clk_en_o};
  endfunction

  task automatic chk(string tag, logic [12:0] exp);
    n_tests++;
    if (obs() !== exp) begin
      n_fail++;
      $display("FAIL %s bus act=%b exp=%b t=%0t", tag, obs(), exp, $time);
    end
  endtask

  task automatic chk_addr(string tag, logic [31:0] exp);
    n_tests++;
    if (addr_o !== exp) begin
      n_fail++;
      $display("FAIL %s addr act=%h exp=%h", tag, addr_o, exp);
    end
  endtask

  task automatic chk_rdy(string tag, logic exp);
    n_tests++;
    if (ready_o !== exp) begin
      n_fail++;
      $display("FAIL %s ready act=%b exp=%b", tag, ready_o, exp);
    end
  endtask

  // enabled lanes per requirement R6, expressed as a byte window
  function automatic logic [3:0] exp_mask(logic [1:0] sz, logic [1:0] lo, logic ln, logic b16);
    int len, start, lanes;
    logic [3:0] m = 4'hF;
    if (ln) return 4'h0;
    lanes = b16 ? 2 : 4;
    len   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (len > lanes) len = lanes;
    start = (int'(lo) % lanes) / len * len;
    for (int i = 0; i < 4; i++)
      if (i >= start && i < start + len) m[i] = 1'b0;
    return m;
  endfunction

  task automatic do_access(logic [31:0] a, logic we, logic [1:0] sz, logic ln,
                           logic b16, logic [2:0] mt);
    logic a2, a3, sd, up, s2n, s3n;
    int n, stp;
    logic [31:0] base;
    @(negedge clk_i);
    req_addr_i = a; req_we_i = we; req_size_i = sz; req_line_i = ln;
    bus16_i = b16; mem_type_i = mt; req_i = 1'b1;
    @(posedge clk_i); #1; req_i = 1'b0;
    a2 = (a[31:26] == 6'b000010);
    a3 = (a[31:26] == 6'b000011);
    sd = (a2 && mt == 3'b011) || (a3 && (mt == 3'b011 || mt == 3'b010));
    if (!sd) begin
      chk("R1 ignored", IDLE_V);
      chk_rdy("R1 ignored", 1'b1);
      return;
    end
    up = a[25]; s2n = !a2; s3n = !a3;
    n = ln ? (b16 ? 8 : 4) : 1;
    stp = b16 ? 2 : 4;
    base = ln ? {a[31:4], 4'h0} : a;
    chk("R3 R2 actv", {s2n, s3n, !up, up, 1'b1, 1'b1, 1'b1, 1'b0, 4'hF, 1'b1});
    chk_addr("R3 actv", base);
    for (int k = 0; k < TRCD - 1; k++) begin
      @(posedge clk_i); #1;
      chk("R3 nop", IDLE_V);
    end
    for (int j = 0; j < n; j++) begin
      @(posedge clk_i); #1;
      chk(ln ? "R5 R6 R2 line" : "R4 R6 R2 single",
          {s2n, s3n, 1'b1, 1'b1, !up, up, !we, (j == n - 1), exp_mask(sz, a[1:0], ln, b16), 1'b1});
      chk_addr(ln ? "R5 col" : "R4 col", base + 32'(j * stp));
    end
    @(posedge clk_i); #1;
    chk("R11 back idle", IDLE_V);
    chk_rdy("R11 back idle", 1'b1);
  endtask

  task automatic do_special(logic rf, logic ms, logic se, logic rq, logic [2:0] mt,
                            logic [31:0] a);
    logic s2n, s3n, none;
    @(negedge clk_i);
    refresh_i = rf; mode_set_i = ms; self_enter_i = se; req_i = rq;
    mem_type_i = mt; req_addr_i = a; req_line_i = 0; req_size_i = 2;
    @(posedge clk_i); #1;
    refresh_i = 0; mode_set_i = 0; self_enter_i = 0; req_i = 0;
    s2n = (mt != 3'b011); s3n = !(mt == 3'b011 || mt == 3'b010);
    none = s2n && s3n;
    if (none) begin
      chk("R1 R7 no sdram area", IDLE_V);
      chk_rdy("R1 no sdram area", 1'b1);
    end else if (se) begin
      chk("R9 R11 self entry", {s2n, s3n, 4'b0000, 1'b1, 1'b0, 4'hF, 1'b0});
      @(negedge clk_i); req_i = 1'b1; refresh_i = 1'b1;
      for (int k = 0; k < 3; k++) begin
        @(posedge clk_i); #1;
        chk("R9 self hold", {7'b1111111, 1'b0, 4'hF, 1'b0});
        chk_rdy("R9 self hold", 1'b0);
      end
      @(negedge clk_i); req_i = 1'b0; refresh_i = 1'b0; self_exit_i = 1'b1;
      @(posedge clk_i); #1; self_exit_i = 1'b0;
      chk("R9 self exit", IDLE_V);
      chk_rdy("R9 self exit", 1'b1);
    end else if (rf) begin
      chk("R7 R11 refresh", {s2n, s3n, 4'b0000, 1'b1, 1'b0, 4'hF, 1'b1});
      @(posedge clk_i); #1;
      chk("R7 after refresh", IDLE_V);
    end else if (ms) begin
      chk("R8 R11 mode set", {s2n, s3n, 4'b0000, 1'b0, 1'b0, 4'hF, 1'b1});
      chk_addr("R8 mode value", a);
      @(posedge clk_i); #1;
      chk("R8 after mode set", IDLE_V);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL R11 watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    #9;
    chk("R12 in reset", IDLE_V);
    chk_rdy("R12 in reset", 1'b1);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R12 after reset", IDLE_V);

    // area / half boundaries
    do_access(32'h09FF_FFF0, 0, 2, 0, 0, 3'b011);
    do_access(32'h0A00_0000, 1, 2, 0, 0, 3'b011);
    do_access(32'h0BFF_FFFC, 0, 2, 0, 0, 3'b011);
    do_access(32'h0C00_0000, 1, 2, 0, 0, 3'b010);
    do_access(32'h0E00_0004, 0, 2, 0, 0, 3'b010);
    do_access(32'h0800_0000, 0, 2, 0, 0, 3'b010);   // area 2 not SDRAM
    do_access(32'h1000_0000, 0, 2, 0, 0, 3'b011);   // outside both areas
    do_access(32'h07FF_FFFC, 1, 2, 0, 0, 3'b011);
    do_access(32'h0C00_0000, 0, 2, 0, 0, 3'b000);
    // lanes
    for (int i = 0; i < 4; i++) do_access(32'h0C00_0100 + 32'(i), 1, 0, 0, 0, 3'b011);
    for (int i = 0; i < 4; i++) do_access(32'h0A00_0100 + 32'(i), 0, 1, 0, 1, 3'b011);
    do_access(32'h0800_0202, 1, 1, 0, 0, 3'b011);
    do_access(32'h0800_0200, 0, 2, 0, 1, 3'b011);
    // lines
    do_access(32'h0C00_001A, 0, 2, 1, 0, 3'b011);
    do_access(32'h0E00_0036, 1, 2, 1, 1, 3'b010);
    do_access(32'h0A00_FFFF, 0, 0, 1, 1, 3'b011);
    // refresh, mode set, self-refresh, priority
    do_special(1, 0, 0, 0, 3'b011, 32'h0);
    do_special(1, 0, 0, 0, 3'b010, 32'h0);
    do_special(1, 0, 0, 0, 3'b000, 32'h0);
    do_special(0, 1, 0, 0, 3'b011, 32'h0000_0230);
    do_special(1, 1, 0, 1, 3'b011, 32'h0C00_0000);
    do_special(0, 1, 0, 1, 3'b010, 32'h0C00_0040);
    do_special(1, 1, 1, 1, 3'b011, 32'h0C00_0000);
    do_special(0, 0, 1, 0, 3'b010, 32'h0);
    do_special(0, 0, 1, 0, 3'b001, 32'h0);

    // constrained random traffic
    for (int it = 0; it < 300; it++) begin
      logic [31:0] a;
      logic [2:0]  mt;
      a  = ($urandom % 8 != 0) ? (32'h0800_0000 | ($urandom & 32'h07FF_FFFF)) : $urandom;
      case ($urandom % 4)
        0: mt = 3'b010;
        1: mt = 3'b000;
        default: mt = 3'b011;
      endcase
      if ($urandom % 10 == 0)
        do_special(1'($urandom % 2), 1'($urandom % 2), 1'b0, 1'b0, mt, a);
      else
        do_access(a, 1'($urandom % 2), 2'($urandom % 3), 1'($urandom % 3 == 0),
                  1'($urandom % 2), mt);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule